// File: doc/BRIEF.md
# Processor Clock Level Change Sequencer

This block moves a processor core clock from one performance level to another without software stepping through the clock-generator registers. A requester hands over a pair of level indices, the current one and the target. The block looks up the target's PLL setting and divider words in internal tables. It then drives a simplified clock-generation interface in the correct order, and waits on each status input before it takes the next step.

There are sixteen levels. Index 0 is the fastest and index 15 the slowest, with 100 MHz between neighbours. Only indices 7 to 15 can be used. When the PLL's multiplier and pre-divider stay the same, only the post-divider is rewritten. Otherwise the core is moved to the alternate PLL while the main PLL relocks, and then moved back. The direction of the change decides whether the dividers or the PLL are changed first.

The request port is valid/ready. A request is taken on a clock edge where both `req_valid_i` and `req_ready_o` are high. `req_ready_o` is high only while the block is idle. A requester that holds valid while ready is low has nothing taken, and its request has no effect. The status inputs must show the effect of a write from the cycle after its strobe.

Top module: `clk_level_seq`

## Requirements
- R1: `req_ready_o` is high only when idle. `busy_o` goes high in the cycle after acceptance and stays high through a single-cycle `done_o` pulse. A request presented while busy is not taken and changes neither the level reached nor the write activity.
- R2: After reset the block is idle with `cur_level_o` = 9, `err_o` = 0 and `mux_sel_o` = 0 (main PLL). `pll_cfg_o` is 0x00640300, `div0_o` is 0x01137720, `div1_o` is 0x00000020 and `lock_cnt_o` is 0.
- R3: When the target index is below the current index (speeding up), both divider writes happen before any PLL write.
- R4: When the target index is above the current index (slowing down), the PLL work finishes before the first divider write.
- R5: If bits 25:8 of the old and new PLL words are equal, the block makes one `pll_wr_o` write. That write changes only bits 2:0. There is no mux switch and no lock-count load.
- R6: The full PLL change runs in this order:
  - set `mux_sel_o` = 1 and wait for `mux_stat_i` = 2;
  - strobe `lock_wr_o` with `lock_cnt_o` = pre-divider × 250;
  - on the next cycle, strobe `pll_wr_o` and wait for `pll_locked_i`;
  - set `mux_sel_o` = 0 and wait for `mux_stat_i` = 1.
- R7: The PLL word holds the multiplier in bits 25:16, the pre-divider in bits 13:8 and the post-divider in bits 2:0. All other bits are zero. The values (multiplier, pre-divider, post-divider) for each level are:
  - level 7: (125,3,0)
  - level 8: (150,4,0)
  - level 9: (100,3,0)
  - level 10: (175,3,1)
  - level 11: (200,4,1)
  - level 12: (125,3,1)
  - level 13: (100,3,1)
  - level 14: (200,4,2)
  - level 15: (100,3,2)
- R8: The first divider word holds field k in bits 4k+2:4k. Its values per level are:
  - levels 7 and 8: 0x02147720
  - level 9: 0x01137720
  - level 10: 0x01137710
  - levels 11 and 12: 0x01127710
  - levels 13 to 15: 0x01117710

  The second divider word is 0x00000020 for every usable level. The second word is written only once `div0_busy_i & 0x11111111` is zero, and the change continues only once `div1_busy_i & 0x11` is zero. All other status bits are ignored.
- R9: A request whose target equals the current index gives a `done_o` pulse with no write strobe of any kind.
- R10: A request whose target is below 7 gives a `done_o` pulse with `rej_o` high. It causes no write strobe and leaves `cur_level_o` unchanged.
- R11: If a wait lasts more than `tmo_lim_i` cycles, `err_o` is set and the block returns to idle without a `done_o` pulse. `cur_level_o` keeps its value. `err_o` stays set until reset.
- R12: `cur_level_o` takes the target index in the cycle of the `done_o` pulse that ends a successful change, and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (idle) |
| req_old_i | input | 4 | Current level index of the request |
| req_new_i | input | 4 | Target level index of the request |
| busy_o | output | 1 | Change in progress |
| done_o | output | 1 | Single-cycle completion pulse |
| rej_o | output | 1 | Qualifies `done_o`: target refused |
| err_o | output | 1 | Sticky wait-timeout flag |
| cur_level_o | output | 4 | Level reached by the last successful change |
| tmo_lim_i | input | 16 | Wait timeout limit in cycles |
| mux_sel_o | output | 1 | Core source select: 0 main PLL, 1 alternate PLL |
| mux_stat_i | input | 3 | Mux status: 1 main, 2 alternate |
| pll_cfg_o | output | 32 | PLL setting word |
| pll_wr_o | output | 1 | PLL setting write strobe |
| lock_cnt_o | output | 16 | PLL lock count |
| lock_wr_o | output | 1 | Lock count write strobe |
| pll_locked_i | input | 1 | PLL lock flag |
| div0_o | output | 32 | First divider word |
| div0_wr_o | output | 1 | First divider write strobe |
| div0_busy_i | input | 32 | First divider status |
| div1_o | output | 32 | Second divider word |
| div1_wr_o | output | 1 | Second divider write strobe |
| div1_busy_i | input | 8 | Second divider status |

## Verification
The change is tried in both directions on both the shortcut and the full path: 9 to 13, 13 to 9, 9 to 10 and 10 to 8. Each run records its sequence of strobes and mux edges, so a wrong order, a missing mux step or a wrong path choice shows up as a different sequence. Equal-index and unsupported targets separate doing nothing from refusing. A request held during a busy change separates ignoring it from queueing it. The bench's status models set busy bits outside the masks, so a decoder that does not mask those bits stalls and shows up as a timeout. A lock flag that never rises checks the timeout path and that the level is left unchanged.

// File: rtl/clk_level_pkg.sv
package clk_level_pkg;

  localparam int unsigned LVL_W = 4;
  localparam logic [LVL_W-1:0] LVL_MIN_OK = 4'd7;
  localparam logic [LVL_W-1:0] LVL_SAFE   = 4'd9;

  localparam int unsigned M_LSB = 16;
  localparam int unsigned P_LSB = 8;
  localparam int unsigned P_W   = 6;
  localparam logic [31:0] S_MASK   = 32'h0000_0007;
  localparam logic [31:0] MP_MASK  = 32'h03FF_3F00;
  localparam logic [31:0] ALL_MASK = MP_MASK | S_MASK;

  localparam logic [31:0] DIV0_BUSY_MASK = 32'h1111_1111;
  localparam logic [7:0]  DIV1_BUSY_MASK = 8'h11;
  localparam logic [2:0]  STAT_MAIN = 3'd1;
  localparam logic [2:0]  STAT_ALT  = 3'd2;
  localparam int unsigned DIV0_FIELDS = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_DIV0_WR, S_DIV0_WAIT, S_DIV1_WR, S_DIV1_WAIT,
    S_MUX_ALT, S_ALT_WAIT, S_LOCK_LD, S_PLL_WR, S_LOCK_WAIT,
    S_MUX_MAIN, S_MAIN_WAIT, S_SDIV_WR, S_DONE
  } seq_state_e;

  function automatic logic [31:0] pack_pll(input int m, input int p, input int s);
    logic [31:0] w;
    w = '0;
    w[M_LSB +: 10]  = 10'(m);
    w[P_LSB +: P_W] = 6'(p);
    w[2:0]          = 3'(s);
    return w;
  endfunction

  function automatic logic [31:0] pll_word(input logic [LVL_W-1:0] lvl);
    logic [31:0] w;
    case (lvl)
      4'd7:    w = pack_pll(125, 3, 0);
      4'd8:    w = pack_pll(150, 4, 0);
      4'd9:    w = pack_pll(100, 3, 0);
      4'd10:   w = pack_pll(175, 3, 1);
      4'd11:   w = pack_pll(200, 4, 1);
      4'd12:   w = pack_pll(125, 3, 1);
      4'd13:   w = pack_pll(100, 3, 1);
      4'd14:   w = pack_pll(200, 4, 2);
      4'd15:   w = pack_pll(100, 3, 2);
      default: w = '0;
    endcase
    return w;
  endfunction

  // Field values follow from the level: core-data and PLL-side ratios shrink
  // in steps, the trace-bus ratio drops by one every two levels.
  function automatic logic [31:0] div0_word(input logic [LVL_W-1:0] lvl);
    logic [2:0]       f [DIV0_FIELDS];
    logic [LVL_W-1:0] off;
    logic [31:0]      w;
    w   = '0;
    off = lvl - LVL_MIN_OK;
    if (lvl >= LVL_MIN_OK) begin
      f[0] = 3'd0;
      f[1] = (lvl <= 4'd9) ? 3'd2 : 3'd1;
      f[2] = 3'd7;
      f[3] = 3'd7;
      f[4] = (lvl <= 4'd12) ? 3'd4 - 3'(off >> 1) : 3'd1;
      f[5] = 3'd1;
      f[6] = (lvl <= 4'd8) ? 3'd2 : 3'd1;
      f[7] = 3'd0;
      for (int k = 0; k < DIV0_FIELDS; k++) w[4*k +: 3] = f[k];
    end
    return w;
  endfunction

  function automatic logic [31:0] div1_word(input logic [LVL_W-1:0] lvl);
    return (lvl >= LVL_MIN_OK) ? 32'h0000_0020 : 32'h0;
  endfunction

endpackage

// File: rtl/clk_wait_timer.sv
module clk_wait_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q >= lim_i);
endmodule

// File: rtl/clk_level_fsm.sv
module clk_level_fsm
  import clk_level_pkg::*;
#(
  parameter int unsigned     LOCK_W    = 16,
  parameter int unsigned     LOCK_MULT = 250,
  parameter logic [LVL_W-1:0] RST_LVL  = LVL_SAFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [LVL_W-1:0] req_old_i,
  input  logic [LVL_W-1:0] req_new_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             rej_o,
  output logic             err_o,
  output logic [LVL_W-1:0] cur_level_o,
  output logic             wait_o,
  input  logic             expired_i,
  output logic             mux_sel_o,
  input  logic [2:0]       mux_stat_i,
  output logic [31:0]      pll_cfg_o,
  output logic             pll_wr_o,
  output logic [LOCK_W-1:0] lock_cnt_o,
  output logic             lock_wr_o,
  input  logic             pll_locked_i,
  output logic [31:0]      div0_o,
  output logic             div0_wr_o,
  input  logic [31:0]      div0_busy_i,
  output logic [31:0]      div1_o,
  output logic             div1_wr_o,
  input  logic [7:0]       div1_busy_i
);
  seq_state_e state_q, state_d;
  logic [LVL_W-1:0] old_q, new_q, cur_q;
  logic div_pend_q, div_pend_d, pll_pend_q, pll_pend_d;
  logic rej_q, err_q, mux_q, tmo_hit;
  logic [31:0] pll_q, div0_q, div1_q;
  logic [LOCK_W-1:0] lock_q;
  logic [31:0] pw_new, pw_old;
  logic fast, full;

  assign pw_new = pll_word(new_q);
  assign pw_old = pll_word(old_q);
  assign fast   = new_q < old_q;
  assign full   = ((pw_new ^ pw_old) & MP_MASK) != '0;

  function automatic seq_state_e pick(input logic dp, input logic pp,
                                      input logic fst, input logic ful);
    if (dp && (fst || !pp)) return S_DIV0_WR;
    else if (pp)            return ful ? S_MUX_ALT : S_SDIV_WR;
    else                    return S_DONE;
  endfunction

  always_comb begin
    state_d    = state_q;
    div_pend_d = div_pend_q;
    pll_pend_d = pll_pend_q;
    tmo_hit    = 1'b0;
    case (state_q)
      S_IDLE: if (req_valid_i) begin
        state_d    = (req_new_i < LVL_MIN_OK || req_new_i == req_old_i) ? S_DONE : S_START;
        div_pend_d = 1'b1;
        pll_pend_d = 1'b1;
      end
      S_START:     state_d = pick(div_pend_q, pll_pend_q, fast, full);
      S_DIV0_WR:   state_d = S_DIV0_WAIT;
      S_DIV0_WAIT: if ((div0_busy_i & DIV0_BUSY_MASK) == '0) state_d = S_DIV1_WR;
                   else if (expired_i) tmo_hit = 1'b1;
      S_DIV1_WR:   state_d = S_DIV1_WAIT;
      S_DIV1_WAIT: if ((div1_busy_i & DIV1_BUSY_MASK) == '0) begin
                     div_pend_d = 1'b0;
                     state_d    = pick(1'b0, pll_pend_q, fast, full);
                   end else if (expired_i) tmo_hit = 1'b1;
      S_MUX_ALT:   state_d = S_ALT_WAIT;
      S_ALT_WAIT:  if (mux_stat_i == STAT_ALT) state_d = S_LOCK_LD;
                   else if (expired_i) tmo_hit = 1'b1;
      S_LOCK_LD:   state_d = S_PLL_WR;
      S_PLL_WR:    state_d = S_LOCK_WAIT;
      S_LOCK_WAIT: if (pll_locked_i) state_d = S_MUX_MAIN;
                   else if (expired_i) tmo_hit = 1'b1;
      S_MUX_MAIN:  state_d = S_MAIN_WAIT;
      S_MAIN_WAIT: if (mux_stat_i == STAT_MAIN) begin
                     pll_pend_d = 1'b0;
                     state_d    = pick(div_pend_q, 1'b0, fast, full);
                   end else if (expired_i) tmo_hit = 1'b1;
      S_SDIV_WR: begin
        pll_pend_d = 1'b0;
        state_d    = pick(div_pend_q, 1'b0, fast, full);
      end
      S_DONE:      state_d = S_IDLE;
      default:     state_d = S_IDLE;
    endcase
    if (tmo_hit) state_d = S_IDLE;
  end

  // Write strobes present the new word for one cycle; the held copy follows.
  assign pll_wr_o  = (state_q == S_PLL_WR) || (state_q == S_SDIV_WR);
  assign lock_wr_o = (state_q == S_LOCK_LD);
  assign div0_wr_o = (state_q == S_DIV0_WR);
  assign div1_wr_o = (state_q == S_DIV1_WR);

  always_comb begin
    if (state_q == S_PLL_WR)       pll_cfg_o = (pll_q & ~ALL_MASK) | pw_new;
    else if (state_q == S_SDIV_WR) pll_cfg_o = (pll_q & ~S_MASK) | (pw_new & S_MASK);
    else                           pll_cfg_o = pll_q;
  end

  assign lock_cnt_o = lock_wr_o ? LOCK_W'(pw_new[P_LSB +: P_W]) * LOCK_W'(LOCK_MULT) : lock_q;
  assign div0_o     = div0_wr_o ? div0_word(new_q) : div0_q;
  assign div1_o     = div1_wr_o ? div1_word(new_q) : div1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      old_q      <= RST_LVL;
      new_q      <= RST_LVL;
      cur_q      <= RST_LVL;
      div_pend_q <= 1'b0;
      pll_pend_q <= 1'b0;
      rej_q      <= 1'b0;
      err_q      <= 1'b0;
      mux_q      <= 1'b0;
      pll_q      <= pll_word(RST_LVL);
      div0_q     <= div0_word(RST_LVL);
      div1_q     <= div1_word(RST_LVL);
      lock_q     <= '0;
    end else begin
      state_q    <= state_d;
      div_pend_q <= div_pend_d;
      pll_pend_q <= pll_pend_d;
      if (state_q == S_IDLE && req_valid_i) begin
        old_q <= req_old_i;
        new_q <= req_new_i;
        rej_q <= req_new_i < LVL_MIN_OK;
      end
      if (state_d == S_DONE && state_q != S_IDLE && state_q != S_DONE) cur_q <= new_q;
      if (tmo_hit)                 err_q <= 1'b1;
      if (state_q == S_MUX_ALT)    mux_q <= 1'b1;
      if (state_q == S_MUX_MAIN)   mux_q <= 1'b0;
      if (pll_wr_o)                pll_q <= pll_cfg_o;
      if (lock_wr_o)               lock_q <= lock_cnt_o;
      if (div0_wr_o)               div0_q <= div0_o;
      if (div1_wr_o)               div1_q <= div1_o;
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign rej_o       = done_o && rej_q;
  assign err_o       = err_q;
  assign cur_level_o = cur_q;
  assign mux_sel_o   = mux_q;
  assign wait_o      = (state_q == S_DIV0_WAIT) || (state_q == S_DIV1_WAIT) ||
                       (state_q == S_ALT_WAIT)  || (state_q == S_LOCK_WAIT) ||
                       (state_q == S_MAIN_WAIT);
endmodule

// File: rtl/clk_level_seq.sv
module clk_level_seq
  import clk_level_pkg::*;
#(
  parameter int unsigned TMO_W     = 16,
  parameter int unsigned LOCK_W    = 16,
  parameter int unsigned LOCK_MULT = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [3:0]        req_old_i,
  input  logic [3:0]        req_new_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rej_o,
  output logic              err_o,
  output logic [3:0]        cur_level_o,
  input  logic [TMO_W-1:0]  tmo_lim_i,
  output logic              mux_sel_o,
  input  logic [2:0]        mux_stat_i,
  output logic [31:0]       pll_cfg_o,
  output logic              pll_wr_o,
  output logic [LOCK_W-1:0] lock_cnt_o,
  output logic              lock_wr_o,
  input  logic              pll_locked_i,
  output logic [31:0]       div0_o,
  output logic              div0_wr_o,
  input  logic [31:0]       div0_busy_i,
  output logic [31:0]       div1_o,
  output logic              div1_wr_o,
  input  logic [7:0]        div1_busy_i
);
  logic wait_w, expired_w;

  clk_wait_timer #(.CNT_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(wait_w), .lim_i(tmo_lim_i), .expired_o(expired_w)
  );

  clk_level_fsm #(.LOCK_W(LOCK_W), .LOCK_MULT(LOCK_MULT), .RST_LVL(LVL_SAFE)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_old_i(req_old_i), .req_new_i(req_new_i),
    .busy_o(busy_o), .done_o(done_o), .rej_o(rej_o), .err_o(err_o),
    .cur_level_o(cur_level_o), .wait_o(wait_w), .expired_i(expired_w),
    .mux_sel_o(mux_sel_o), .mux_stat_i(mux_stat_i),
    .pll_cfg_o(pll_cfg_o), .pll_wr_o(pll_wr_o),
    .lock_cnt_o(lock_cnt_o), .lock_wr_o(lock_wr_o), .pll_locked_i(pll_locked_i),
    .div0_o(div0_o), .div0_wr_o(div0_wr_o), .div0_busy_i(div0_busy_i),
    .div1_o(div1_o), .div1_wr_o(div1_wr_o), .div1_busy_i(div1_busy_i)
  );
endmodule

// File: rtl/clk_level_seq_chk.sv
module clk_level_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [3:0]  cur_level_o,
  input logic        mux_sel_o,
  input logic        pll_wr_o,
  input logic        lock_wr_o,
  input logic        div1_wr_o,
  input logic [31:0] div0_busy_i
);
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> busy_o);
  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r1_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);
  a_r12_level_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_level_o) |-> done_o);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  a_r6_lock_then_pll: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr_o |=> (pll_wr_o && mux_sel_o));
  a_r8_div1_after_div0: assert property (@(posedge clk) disable iff (!rst_n)
    div1_wr_o |-> ((div0_busy_i & 32'h1111_1111) == 32'h0));
  a_r6_mux_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mux_sel_o) |-> busy_o);
endmodule

bind clk_level_seq clk_level_seq_chk u_chk (.*);

// File: tb/clk_level_seq_tb_top.sv
module clk_level_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [3:0]  req_old = 4'd9, req_new = 4'd9;
  logic        req_ready, busy, done, rej, err;
  logic [3:0]  cur_level;
  logic [15:0] tmo_lim = 16'd200;
  logic        mux_sel;
  logic [2:0]  mux_stat;
  logic [31:0] pll_cfg, div0, div1;
  logic        pll_wr, lock_wr, div0_wr, div1_wr;
  logic [15:0] lock_cnt;
  logic        pll_locked;
  logic [31:0] div0_busy;
  logic [7:0]  div1_busy;

  clk_level_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_old_i(req_old), .req_new_i(req_new), .busy_o(busy), .done_o(done),
    .rej_o(rej), .err_o(err), .cur_level_o(cur_level), .tmo_lim_i(tmo_lim),
    .mux_sel_o(mux_sel), .mux_stat_i(mux_stat), .pll_cfg_o(pll_cfg), .pll_wr_o(pll_wr),
    .lock_cnt_o(lock_cnt), .lock_wr_o(lock_wr), .pll_locked_i(pll_locked),
    .div0_o(div0), .div0_wr_o(div0_wr), .div0_busy_i(div0_busy),
    .div1_o(div1), .div1_wr_o(div1_wr), .div1_busy_i(div1_busy)
  );

  // Clock-generator stand-ins
  logic hang_lock = 1'b0;
  logic [2:0] sel_sh;
  int b0cnt, b1cnt, lcnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sh <= '0; b0cnt <= 0; b1cnt <= 0; lcnt <= 0; pll_locked <= 1'b1;
    end else begin
      sel_sh <= {sel_sh[1:0], mux_sel};
      if (div0_wr) b0cnt <= 5; else if (b0cnt != 0) b0cnt <= b0cnt - 1;
      if (div1_wr) b1cnt <= 3; else if (b1cnt != 0) b1cnt <= b1cnt - 1;
      if (pll_wr && mux_sel) begin
        pll_locked <= 1'b0; lcnt <= int'(lock_cnt) / 50;
      end else if (!pll_locked && !hang_lock) begin
        if (lcnt <= 1) pll_locked <= 1'b1; else lcnt <= lcnt - 1;
      end
    end
  end
  assign mux_stat  = sel_shift_stat(sel_sh[2]);
  assign div0_busy = ((b0cnt != 0) ? 32'h1111_1111 : 32'h0) | 32'hEEEE_EEEE;
  assign div1_busy = ((b1cnt != 0) ? 8'h11 : 8'h00) | 8'hEE;

  function automatic logic [2:0] sel_shift_stat(input logic s);
    return s ? 3'd2 : 3'd1;
  endfunction

  // Event recorder: 1 div0 wr, 2 div1 wr, 3 mux to alt, 4 lock load,
  // 5 full PLL write, 6 mux to main, 7 post-divider-only write
  int ev_code;
  int order_bad;
  logic prev_sel;
  logic [31:0] last_pll, last_div0, last_div1;
  logic [15:0] last_lock;
  always @(negedge clk) begin
    if (rst_n) begin
      if (div0_wr) begin ev_code = ev_code * 10 + 1; last_div0 = div0; end
      if (div1_wr) begin
        ev_code = ev_code * 10 + 2; last_div1 = div1;
        if (b0cnt != 0) order_bad = order_bad + 1;
      end
      if (mux_sel && !prev_sel) ev_code = ev_code * 10 + 3;
      if (lock_wr) begin ev_code = ev_code * 10 + 4; last_lock = lock_cnt; end
      if (pll_wr) begin ev_code = ev_code * 10 + (mux_sel ? 5 : 7); last_pll = pll_cfg; end
      if (!mux_sel && prev_sel) ev_code = ev_code * 10 + 6;
    end
    prev_sel = mux_sel;
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input string what, input longint act, input longint exp);
    chk(act == exp, tag, what, act, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; hang_lock = 1'b0;
    ev_code = 0; order_bad = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input logic [3:0] o, input logic [3:0] n);
    ev_code = 0; order_bad = 0;
    @(negedge clk);
    req_old = o; req_new = n; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end(output bit saw, output bit rj, output int cyc);
    saw = 0; rj = 0; cyc = 0;
    for (int i = 0; i < 600; i++) begin
      cyc = i;
      if (done) begin saw = 1; rj = rej; break; end
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic step(input string tag, input logic [3:0] o, input logic [3:0] n,
                      input int exp_seq, input bit exp_rej);
    bit saw, rj; int cyc;
    issue(o, n);
    wait_end(saw, rj, cyc);
    chk_eq(tag, "done pulse seen", saw, 1);
    chk_eq(tag, "reject flag", rj, exp_rej);
    @(negedge clk);
    chk_eq("R1", "done lasts one cycle", done, 0);
    chk_eq(tag, "write sequence", ev_code, exp_seq);
  endtask

  task automatic t_reset();
    do_reset();
    chk_eq("R2", "cur level", cur_level, 9);
    chk_eq("R2", "ready", req_ready, 1);
    chk_eq("R2", "busy", busy, 0);
    chk_eq("R2", "err", err, 0);
    chk_eq("R2", "mux sel", mux_sel, 0);
    chk_eq("R2", "pll word", pll_cfg, 32'h0064_0300);
    chk_eq("R2", "div0 word", div0, 32'h0113_7720);
    chk_eq("R2", "div1 word", div1, 32'h0000_0020);
    chk_eq("R2", "lock count", lock_cnt, 0);
  endtask

  task automatic t_slow_short();
    step("R4", 4'd9, 4'd13, 712, 0);
    chk_eq("R5", "s-only pll word", last_pll, 32'h0064_0301);
    chk_eq("R8", "div0 level 13", last_div0, 32'h0111_7710);
    chk_eq("R8", "div1 level 13", last_div1, 32'h0000_0020);
    chk_eq("R12", "level after 9->13", cur_level, 13);
  endtask

  task automatic t_fast_short();
    step("R3", 4'd13, 4'd9, 127, 0);
    chk_eq("R5", "s-only pll word back", last_pll, 32'h0064_0300);
    chk_eq("R8", "div0 level 9", last_div0, 32'h0113_7720);
    chk_eq("R8", "div1 waited on div0", order_bad, 0);
    chk_eq("R12", "level after 13->9", cur_level, 9);
  endtask

  task automatic t_slow_full();
    step("R4", 4'd9, 4'd10, 345612, 0);
    chk_eq("R6", "lock count p=3", last_lock, 750);
    chk_eq("R7", "pll word level 10", last_pll, 32'h00AF_0301);
    chk_eq("R8", "div0 level 10", last_div0, 32'h0113_7710);
    chk_eq("R6", "mux back on main", mux_sel, 0);
    chk_eq("R12", "level after 9->10", cur_level, 10);
  endtask

  task automatic t_fast_full();
    step("R3", 4'd10, 4'd8, 123456, 0);
    chk_eq("R6", "lock count p=4", last_lock, 1000);
    chk_eq("R7", "pll word level 8", last_pll, 32'h0096_0400);
    chk_eq("R8", "div0 level 8", last_div0, 32'h0214_7720);
    chk_eq("R12", "level after 10->8", cur_level, 8);
  endtask

  task automatic t_same();
    step("R9", 4'd8, 4'd8, 0, 0);
    chk_eq("R9", "level unchanged", cur_level, 8);
  endtask

  task automatic t_reject();
    step("R10", 4'd8, 4'd3, 0, 1);
    chk_eq("R10", "level unchanged", cur_level, 8);
    chk_eq("R10", "pll word untouched", pll_cfg, 32'h0096_0400);
  endtask

  task automatic t_ignore_busy();
    bit saw, rj; int cyc; int not_ready = 0;
    issue(4'd8, 4'd14);
    repeat (4) @(negedge clk);
    req_old = 4'd14; req_new = 4'd7; req_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      if (!req_ready) not_ready++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk_eq("R1", "ready low while busy", not_ready, 3);
    wait_end(saw, rj, cyc);
    chk_eq("R1", "done after busy", saw, 1);
    repeat (30) @(negedge clk);
    chk_eq("R1", "only one change made", ev_code, 345612);
    chk_eq("R1", "level is first target", cur_level, 14);
    chk_eq("R7", "pll word level 14", last_pll, 32'h00C8_0402);
  endtask

  task automatic t_timeout();
    bit saw, rj; int cyc;
    do_reset();
    tmo_lim = 16'd40;
    hang_lock = 1'b1;
    issue(4'd9, 4'd10);
    wait_end(saw, rj, cyc);
    chk_eq("R11", "no done on timeout", saw, 0);
    chk(cyc >= 40 && cyc <= 80, "R11", "cycles to timeout", cyc, 40);
    @(negedge clk);
    chk_eq("R11", "error set", err, 1);
    chk_eq("R11", "back to idle", req_ready, 1);
    chk_eq("R11", "level kept", cur_level, 9);
    repeat (5) @(negedge clk);
    chk_eq("R11", "error sticky", err, 1);
    hang_lock = 1'b0;
    tmo_lim = 16'd200;
  endtask

  initial begin
    t_reset();
    t_slow_short();
    t_fast_short();
    t_slow_full();
    t_fast_full();
    t_same();
    t_reject();
    t_ignore_busy();
    t_timeout();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule